// File: doc/BRIEF.md
# Reference-Locked Clock Multiplier

This block builds a faster clock and a frame strobe from a slow reference, using only the fast system clock `clk`. It synchronizes the selected reference input. It then counts the system-clock cycles between rising edges of that reference and divides the count by a power-of-two factor. The quotient is the half-period, in system-clock cycles, of the synthesized clock. Each new reference rising edge realigns the synthesized clock, so rounding error cannot build up from one reference period to the next.

A second divider counts rising edges of the synthesized clock and raises a frame strobe for one synthesized period out of every 2^(k+4). For example, a 64 kHz reference with a factor of 16 gives a 1.024 MHz clock, and a frame divider code of 3 turns that clock into an 8 kHz strobe. A 16-bit control word sets the reference select, the factor code, the frame code and a run bit. While the run bit is clear, the block passes the reference straight through. The reference must rise at least once every 16384 system cycles. If it does not, a sticky error flag is raised.

Top module: `refsynth_clkgen`

## Requirements
- R1: The control word is decoded as follows: bits [1:0] select the reference input, bits [4:2] hold the factor code n, bits [7:5] hold the frame code k, and bit 15 is the run bit. Bits [14:8] have no effect.
- R2: While the run bit is 0, `synth_clk` equals the selected reference after a two-flop synchronizer, and `fsync` stays 0.
- R3: While running, the synthesized half-period is floor(P / 2^(n+2)) system cycles, with a minimum of 1. P is the measured number of system cycles between synchronized reference rising edges, so the factor is 2^(n+1) and ranges from 2 to 256.
- R4: Each synchronized reference rising edge forces `synth_clk` high and restarts its phase. When P is not an exact multiple of the period, one low phase per reference period is therefore shortened.
- R5: After the run bit is set, `synth_clk` stays 0 until one full reference period has been measured.
- R6: `fsync` goes high together with a `synth_clk` rising edge and stays high for exactly one synthesized period. This repeats once every 2^(k+4) synthesized periods.
- R7: If the period counter reaches 16384 cycles without a reference rising edge, `ovf_err` is set. It stays set until reset, and while it is set `synth_clk` and `fsync` are held at 0.
- R8: Reset drives `synth_clk`, `fsync` and `ovf_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | NREF (4) | Candidate reference clocks, asynchronous |
| ctrl | input | 16 | Control word (select, factor code, frame code, run) |
| synth_clk | output | 1 | Synthesized clock, or the synchronized reference in bypass |
| fsync | output | 1 | Frame strobe, one synthesized period wide |
| ovf_err | output | 1 | Sticky reference-too-slow flag |

## Verification
The bench measures the length of every high phase of `synth_clk` and compares it with the expected truncated quotient. One case has a remainder: its high phases must be 15 cycles where a rounding divider would give 16. The same case must show one low phase of 9 cycles, which appears only if the reference edge realigns the phase; a free-running design would show only 15-cycle low phases. The bench also covers a quotient that truncates to zero, which must clamp to a one-cycle half-period instead of stalling. It checks the frame strobe's width, its spacing and its alignment to `synth_clk` rising edges, and that the error flag survives the return of the reference, since a flag that cleared itself would let the output resume.

// File: rtl/refsynth_clkgen.sv
module refsynth_clkgen #(
  parameter int NREF   = 4,
  parameter int CNT_W  = 14,
  parameter int MUL_W  = 3,
  parameter int FDV_W  = 3,
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREF-1:0]   ref_in,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              synth_clk,
  output logic              fsync,
  output logic              ovf_err
);
  localparam int SEL_W   = $clog2(NREF);
  localparam int MUL_LO  = SEL_W;
  localparam int FDV_LO  = MUL_LO + MUL_W;
  localparam int RUN_BIT = CTRL_W - 1;
  localparam int PER_W   = CNT_W + 1;
  localparam int FC_W    = (1 << FDV_W) + 3;
  localparam int SH_W    = MUL_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             run;
  logic [SEL_W-1:0] sel;
  logic [MUL_W-1:0] mcode;
  logic [FDV_W-1:0] fcode;
  logic             unused_bits;

  assign run   = ctrl[RUN_BIT];
  assign sel   = ctrl[SEL_W-1:0];
  assign mcode = ctrl[MUL_LO +: MUL_W];
  assign fcode = ctrl[FDV_LO +: FDV_W];
  assign unused_bits = ^ctrl[RUN_BIT-1:FDV_LO+FDV_W];

  logic [NREF-1:0] sy1, sy2;
  logic            ref_d;
  logic            ref_s;
  logic            ref_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1   <= '0;
      sy2   <= '0;
      ref_d <= 1'b0;
    end else begin
      sy1   <= ref_in;
      sy2   <= sy1;
      ref_d <= ref_s;
    end
  end

  assign ref_s    = sy2[sel];
  assign ref_rise = run & ref_s & ~ref_d;

  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] ph, ph_next;
  logic [PER_W-1:0] half_raw, half_eff;
  logic [FC_W-1:0]  fcnt, flen_m1;
  logic             started, valid, ovf, syn_q, fs_q;
  logic             syn_next, syn_rise_ev;

  assign half_raw = per_q >> ({{(SH_W-MUL_W){1'b0}}, mcode} + SH_W'(2));
  assign half_eff = (half_raw == '0) ? PER_W'(1) : half_raw;
  assign flen_m1  = (FC_W'(1) << ({1'b0, fcode} + (FDV_W+1)'(4))) - FC_W'(1);

  always_comb begin
    syn_next = 1'b0;
    ph_next  = '0;
    if (ref_rise && started) begin
      syn_next = 1'b1;
      ph_next  = '0;
    end else if (valid) begin
      if (ph >= half_eff - PER_W'(1)) begin
        syn_next = ~syn_q;
        ph_next  = '0;
      end else begin
        syn_next = syn_q;
        ph_next  = ph + PER_W'(1);
      end
    end
  end

  assign syn_rise_ev = syn_next & ~syn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_q   <= '0;
      ph      <= '0;
      started <= 1'b0;
      valid   <= 1'b0;
      ovf     <= 1'b0;
      syn_q   <= 1'b0;
      fcnt    <= '0;
      fs_q    <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      ph      <= '0;
      started <= 1'b0;
      valid   <= 1'b0;
      syn_q   <= 1'b0;
      fcnt    <= '0;
      fs_q    <= 1'b0;
    end else if (ovf) begin
      syn_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      if (ref_rise) begin
        cnt     <= '0;
        started <= 1'b1;
        if (started) begin
          per_q <= PER_W'(cnt) + PER_W'(1);
          valid <= 1'b1;
        end
      end else if (cnt == CNT_MAX) begin
        ovf <= 1'b1;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      syn_q <= syn_next;
      ph    <= ph_next;
      if (syn_rise_ev) begin
        fs_q <= (fcnt >= flen_m1);
        fcnt <= (fcnt >= flen_m1) ? '0 : fcnt + FC_W'(1);
      end
    end
  end

  assign synth_clk = ovf ? 1'b0 : (run ? syn_q : ref_s);
  assign fsync     = fs_q & ~ovf;
  assign ovf_err   = ovf;
endmodule

module refsynth_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic synth_clk,
  input logic fsync,
  input logic ovf_err,
  input logic ref_rise,
  input logic valid
);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  // R7
  ovf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> (!synth_clk && !fsync));

  // R4
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && valid && !ovf_err) |=> (synth_clk || !run));

  // R5
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !valid) |-> !synth_clk);

  // R6
  fsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $rose(fsync)) |-> $rose(synth_clk));
endmodule

bind refsynth_clkgen refsynth_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .synth_clk(synth_clk),
  .fsync(fsync), .ovf_err(ovf_err), .ref_rise(ref_rise), .valid(valid)
);

// File: tb/refsynth_clkgen_tb.sv
module refsynth_clkgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl = '0;
  logic        r0 = 1'b0, r1 = 1'b0, r2 = 1'b0, r3 = 1'b0;
  logic        r3_en = 1'b1;
  logic [3:0]  ref_in;
  logic        synth_clk, fsync, ovf_err;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string cur_tag = "R3";
  int hi_len = 0, lo_len = 0, lo_min = 99999;
  logic prev_s = 1'b0;

  assign ref_in = {r3, r2, r1, r0};

  always #5 clk = ~clk;

  initial forever begin repeat (256) @(negedge clk); r0 = ~r0; end
  initial forever begin repeat (252) @(negedge clk); r1 = ~r1; end
  initial forever begin repeat (128) @(negedge clk); r2 = ~r2; end
  initial forever begin repeat (512) @(negedge clk); r3 = r3_en ? ~r3 : 1'b0; end

  refsynth_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ctrl(ctrl),
    .synth_clk(synth_clk), .fsync(fsync), .ovf_err(ovf_err)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk(input bit run, input int k, input int n, input int s);
    mk = '0;
    mk[15]  = run;
    mk[7:5] = 3'(k);
    mk[4:2] = 3'(n);
    mk[1:0] = 2'(s);
  endfunction

  // monitor: measures high phases and pops expected lengths
  always @(negedge clk) begin
    if (synth_clk) begin
      if (!prev_s && lo_len > 0) begin
        if (lo_len < lo_min) lo_min = lo_len;
        lo_len = 0;
      end
      hi_len++;
    end else begin
      if (prev_s) begin
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(hi_len == e, {cur_tag, " high phase"}, hi_len, e);
        end
        hi_len = 0;
      end
      lo_len++;
    end
    prev_s = synth_clk;
  end

  task automatic push_highs(input int len, input int n, input string tag);
    @(posedge clk);
    cur_tag = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(len);
    while (exp_q.size() > 0) @(posedge clk);
  endtask

  task automatic settle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic count_high(input int c, output int h);
    h = 0;
    for (int i = 0; i < c; i++) begin
      @(negedge clk);
      if (synth_clk) h++;
    end
  endtask

  task automatic fs_meas(input int w_exp, input int p_exp, input string tag);
    logic pf, ps;
    int t, w, p;
    bit seen_fall;
    @(negedge clk);
    pf = fsync; ps = synth_clk; t = 0;
    while (!(fsync && !pf)) begin
      pf = fsync; ps = synth_clk;
      @(negedge clk);
      t++;
      if (t > 3 * p_exp) begin
        chk(0, {tag, " no strobe"}, 0, 1);
        return;
      end
    end
    chk(synth_clk && !ps, {tag, " strobe alignment"}, int'(ps), 0);
    w = 1; p = 0; seen_fall = 0;
    forever begin
      @(negedge clk);
      p++;
      if (!seen_fall) begin
        if (fsync) w++; else seen_fall = 1;
      end else if (fsync) break;
      if (p > 3 * p_exp) break;
    end
    chk(w == w_exp, {tag, " strobe width"}, w, w_exp);
    chk(p == p_exp, {tag, " strobe spacing"}, p, p_exp);
  endtask

  initial begin
    int h;
    repeat (5) @(negedge clk);
    // R8 reset state
    chk(synth_clk == 0, "R8 synth_clk", int'(synth_clk), 0);
    chk(fsync == 0, "R8 fsync", int'(fsync), 0);
    chk(ovf_err == 0, "R8 ovf_err", int'(ovf_err), 0);
    rst_n = 1'b1;

    // R2 bypass follows reference 0 (period 512)
    ctrl = mk(0, 0, 2, 0);
    settle(1600);
    push_highs(256, 2, "R2");
    count_high(600, h);
    h = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (fsync) h++; end
    chk(h == 0, "R2 fsync in bypass", h, 0);

    // R5 warm-up
    ctrl = mk(1, 0, 2, 0);
    count_high(512, h);
    chk(h == 0, "R5 output during first measurement", h, 0);
    settle(1600);
    // R3 factor 8 on 512 -> 32
    push_highs(32, 6, "R3");
    // R6 frame code 0: every 16 periods of 64
    fs_meas(64, 1024, "R6 k0");

    // R3 minimum factor 2 -> 128
    ctrl = mk(1, 0, 0, 0);
    settle(1600);
    push_highs(128, 3, "R3");

    // R1 junk bits ignored
    ctrl = mk(1, 0, 2, 0) | 16'h5500;
    settle(1600);
    push_highs(32, 4, "R1");

    // R6 frame code 3: ratio 128
    ctrl = mk(1, 3, 2, 0);
    settle(1600);
    fs_meas(64, 8192, "R6 k3");

    // R1/R3 select ref 1 (504), factor 16 -> 15 truncated
    ctrl = mk(1, 0, 3, 1);
    settle(1600);
    push_highs(15, 8, "R3");
    // R4 realign gives one short low phase of 9
    @(posedge clk) lo_min = 99999;
    settle(1100);
    chk(lo_min == 9, "R4 shortest low phase", lo_min, 9);

    // R3 clamp: 256 >> 9 = 0 -> 1
    ctrl = mk(1, 0, 7, 2);
    settle(1600);
    push_highs(1, 8, "R3");

    // R1 select ref 3 (1024), factor 256 -> 2
    ctrl = mk(1, 0, 7, 3);
    settle(3200);
    push_highs(2, 8, "R1");

    // R7 overflow
    ctrl = mk(1, 0, 2, 3);
    settle(3200);
    r3_en = 1'b0;
    settle(20000);
    chk(ovf_err == 1, "R7 ovf_err set", int'(ovf_err), 1);
    chk(synth_clk == 0, "R7 synth_clk held", int'(synth_clk), 0);
    chk(fsync == 0, "R7 fsync held", int'(fsync), 0);
    r3_en = 1'b1;
    count_high(3000, h);
    chk(h == 0, "R7 output stays low after reference returns", h, 0);
    chk(ovf_err == 1, "R7 ovf_err sticky", int'(ovf_err), 1);

    // R8 reset clears flag
    rst_n = 1'b0;
    settle(3);
    chk(ovf_err == 0, "R8 ovf_err after reset", int'(ovf_err), 0);
    rst_n = 1'b1;
    settle(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule